// File: doc/BRIEF.md
# Byte-Address Stride Prefetcher

This block observes a stream of cache access events and learns, per load instruction, a constant distance between successive byte addresses. It trains on the complete byte address, not on the cache line address, so access patterns that advance by less than a line are seen as a steady stride. One example is a 48-byte step with 64-byte lines.

Each event carries a program counter, a byte address, a requester ID and four flags: cache miss, write, instruction fetch and prefetch-origin. A small direct-mapped table is indexed by PC bits. When per-requester tracking is on, the requester ID is folded into the index as well. Each entry keeps a tag, the last address, a signed stride and a 2-bit confidence.

Once an entry is confident, the block produces up to DEGREE line-aligned prefetch addresses, one per cycle, over a valid/ready output. Filter inputs restrict training to misses, to reads or to data accesses. A tag option attaches the trigger PC to each prefetch, so that a lower-level prefetcher can train on it.

Top module: `stride_prefetch`

## Requirements
- R1: After reset `pfValid` is low and stays low until a qualifying event triggers.
- R2: The stride is the difference between full byte addresses, with no line masking. A confidence of 2 is reached on the fourth event of a constant stride (48 bytes included), and that event triggers. Confidence starts at 0 on allocation, rises by one on a matching stride (saturating at 3) and falls by one otherwise. The stored stride is replaced when confidence is 0.
- R3: A trigger at address A with stride S produces the candidates A+k*S for k = 1..DEGREE (default 3). Each is aligned down to a 64-byte line, with the address bits [5:0] cleared. Negative strides are supported.
- R4: A candidate line equal to the trigger's line, or to the previously issued line of the same burst, is skipped. No line is issued twice in a row within one burst.
- R5: With `cfgPageStop` set, a candidate whose 4096-byte page (address bits [31:12]) differs from the trigger's page is skipped. With it clear, such a candidate is issued.
- R6: With `cfgPerReq` set, each requester ID keeps its own table entry for the same PC. With it clear, the ID is ignored, and requesters sharing a PC train one entry.
- R7: With `cfgMissOnly` set, events with `evMiss`=0 neither train nor trigger.
- R8: With `cfgReadOnly` set, events with `evWrite`=1 neither train nor trigger.
- R9: With `cfgDataOnly` set, events with `evInstr`=1 neither train nor trigger.
- R10: With `cfgPcTag` set, `pfPc` carries the trigger PC, and events with `evIsPf`=1 train normally. With it clear, `pfPc` is 0 and events with `evIsPf`=1 are ignored.
- R11: While `pfValid` is high and `pfReady` is low, `pfValid` and `pfAddr` hold, unless a new trigger arrives.
- R12: A new trigger while a burst is pending discards the rest of the old burst. The next offered address belongs to the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evValid | input | 1 | Access event present this cycle |
| evPc | input | 32 | PC of the accessing instruction |
| evAddr | input | 32 | Full byte address of the access |
| evMiss | input | 1 | Access missed in the cache |
| evWrite | input | 1 | Access is a write |
| evInstr | input | 1 | Access is an instruction fetch |
| evReqId | input | 2 | Requester ID |
| evIsPf | input | 1 | Event originates from a prefetch |
| cfgMissOnly | input | 1 | Train and trigger on misses only |
| cfgReadOnly | input | 1 | Exclude writes |
| cfgDataOnly | input | 1 | Exclude instruction fetches |
| cfgPerReq | input | 1 | Separate entries per requester |
| cfgPageStop | input | 1 | Skip prefetches into another page |
| cfgPcTag | input | 1 | Tag prefetches with PC; accept prefetch-origin events |
| pfValid | output | 1 | Prefetch address offered |
| pfReady | input | 1 | Consumer accepts the prefetch |
| pfAddr | output | 32 | Line-aligned prefetch address |
| pfPc | output | 32 | Trigger PC, or 0 when tagging is off |

## Verification
The hardest situation to reach from the ports is a squash. A burst must be pending while a second trigger for a confident entry arrives. The stimulus trains an entry with `pfReady` high, drops `pfReady` before the triggering event, and then sends one more matching event while the first candidate is still stalled. Only the new burst may then drain.

The filter tests work differently. Each one first feeds four events that must be ignored, then three qualifying events. If the ignored events had trained the entry, the stream would trigger early, and the scoreboard reports the extra prefetch.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic train;   // qualified event: update table
    logic load;    // start a new burst (squashes any pending one)
    logic step;    // advance the pending burst by one candidate
  } pfStrobe_t;
endpackage

// File: rtl/stride_pf_dp.sv
module stride_pf_dp
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int REQ_W      = 2,
  parameter int IDX_W      = 4,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int DEGREE     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   evPc,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic [REQ_W-1:0]  evReqId,
  input  logic              cfgPerReq,
  input  logic              cfgPageStop,
  input  logic              cfgPcTag,
  input  pfStrobe_t         stb,
  output logic              trigHit,
  output logic              candDrop,
  output logic              lastStep,
  output logic [ADDR_W-1:0] pfAddr,
  output logic [PC_W-1:0]   pfPc
);
  localparam int ENTRIES   = 1 << IDX_W;
  localparam int LINE_BITS = $clog2(LINE_BYTES);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);
  localparam int CNT_W     = $clog2(DEGREE + 1);

  function automatic logic [ADDR_W-1:0] lineOf(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:LINE_BITS], {LINE_BITS{1'b0}}};
  endfunction

  // Stride table
  logic [ENTRIES-1:0]       entValid;
  logic [PC_W-1:0]          entPc     [ENTRIES];
  logic [REQ_W-1:0]         entReq    [ENTRIES];
  logic [ADDR_W-1:0]        entAddr   [ENTRIES];
  logic signed [ADDR_W-1:0] entStride [ENTRIES];
  logic [1:0]               entConf   [ENTRIES];

  logic [REQ_W-1:0]         reqKey;
  logic [IDX_W-1:0]         idx;
  logic                     hit;
  logic signed [ADDR_W-1:0] obsStride;
  logic signed [ADDR_W-1:0] nxtStride;
  logic [1:0]               nxtConf;

  assign reqKey = cfgPerReq ? evReqId : '0;
  assign idx    = evPc[IDX_W+1:2] ^ IDX_W'(reqKey);

  always_comb begin
    hit       = entValid[idx] && (entPc[idx] == evPc) && (entReq[idx] == reqKey);
    obsStride = $signed(evAddr - entAddr[idx]);
    if (obsStride == entStride[idx]) begin
      nxtStride = entStride[idx];
      nxtConf   = (entConf[idx] == 2'd3) ? 2'd3 : entConf[idx] + 2'd1;
    end else begin
      nxtConf   = (entConf[idx] == 2'd0) ? 2'd0 : entConf[idx] - 2'd1;
      nxtStride = (nxtConf == 2'd0) ? obsStride : entStride[idx];
    end
    trigHit = hit && (nxtConf >= 2'd2) && (nxtStride != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          entValid      <= '0;
    else if (stb.train) entValid[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stb.train) begin
      entPc[idx]   <= evPc;
      entReq[idx]  <= reqKey;
      entAddr[idx] <= evAddr;
      if (hit) begin
        entStride[idx] <= nxtStride;
        entConf[idx]   <= nxtConf;
      end else begin
        entStride[idx] <= '0;
        entConf[idx]   <= 2'd0;
      end
    end
  end

  // Burst generator
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] burstStride;
  logic [ADDR_W-1:0] trigLine;
  logic [ADDR_W-1:0] lastLine;
  logic [PC_W-1:0]   burstPc;
  logic [CNT_W-1:0]  kCnt;
  logic [ADDR_W-1:0] candLine;
  logic              crossPage;

  assign candLine  = lineOf(curAddr);
  assign crossPage = candLine[ADDR_W-1:PAGE_BITS] != trigLine[ADDR_W-1:PAGE_BITS];
  assign candDrop  = (candLine == trigLine) || (candLine == lastLine) ||
                     (cfgPageStop && crossPage);
  assign lastStep  = (kCnt == CNT_W'(DEGREE));
  assign pfAddr    = candLine;
  assign pfPc      = cfgPcTag ? burstPc : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr     <= '0;
      burstStride <= '0;
      trigLine    <= '0;
      lastLine    <= '0;
      burstPc     <= '0;
      kCnt        <= '0;
    end else if (stb.load) begin
      curAddr     <= evAddr + $unsigned(nxtStride);
      burstStride <= $unsigned(nxtStride);
      trigLine    <= lineOf(evAddr);
      lastLine    <= lineOf(evAddr);
      burstPc     <= evPc;
      kCnt        <= CNT_W'(1);
    end else if (stb.step) begin
      curAddr <= curAddr + burstStride;
      if (!candDrop) lastLine <= candLine;
      kCnt    <= kCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/stride_pf_ctrl.sv
module stride_pf_ctrl
  import stride_pf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      evValid,
  input  logic      evMiss,
  input  logic      evWrite,
  input  logic      evInstr,
  input  logic      evIsPf,
  input  logic      cfgMissOnly,
  input  logic      cfgReadOnly,
  input  logic      cfgDataOnly,
  input  logic      cfgPcTag,
  input  logic      trigHit,
  input  logic      candDrop,
  input  logic      lastStep,
  input  logic      pfReady,
  output pfStrobe_t stb,
  output logic      pfValid
);
  logic busy;
  logic qual;

  always_comb begin
    qual = evValid
        && (!cfgMissOnly || evMiss)
        && (!cfgReadOnly || !evWrite)
        && (!cfgDataOnly || !evInstr)
        && (!evIsPf || cfgPcTag);
    stb.train = qual;
    stb.load  = qual && trigHit;
    stb.step  = busy && !stb.load && (candDrop || pfReady);
  end

  assign pfValid = busy && !candDrop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     busy <= 1'b0;
    else if (stb.load)             busy <= 1'b1;
    else if (stb.step && lastStep) busy <= 1'b0;
  end
endmodule

// File: rtl/stride_prefetch.sv
module stride_prefetch
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int REQ_W      = 2,
  parameter int IDX_W      = 4,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int DEGREE     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic [PC_W-1:0]   evPc,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic              evMiss,
  input  logic              evWrite,
  input  logic              evInstr,
  input  logic [REQ_W-1:0]  evReqId,
  input  logic              evIsPf,
  input  logic              cfgMissOnly,
  input  logic              cfgReadOnly,
  input  logic              cfgDataOnly,
  input  logic              cfgPerReq,
  input  logic              cfgPageStop,
  input  logic              cfgPcTag,
  output logic              pfValid,
  input  logic              pfReady,
  output logic [ADDR_W-1:0] pfAddr,
  output logic [PC_W-1:0]   pfPc
);
  pfStrobe_t stb;
  logic      trigHit;
  logic      candDrop;
  logic      lastStep;

  stride_pf_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .evValid(evValid), .evMiss(evMiss), .evWrite(evWrite),
    .evInstr(evInstr), .evIsPf(evIsPf),
    .cfgMissOnly(cfgMissOnly), .cfgReadOnly(cfgReadOnly),
    .cfgDataOnly(cfgDataOnly), .cfgPcTag(cfgPcTag),
    .trigHit(trigHit), .candDrop(candDrop), .lastStep(lastStep),
    .pfReady(pfReady), .stb(stb), .pfValid(pfValid)
  );

  stride_pf_dp #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .REQ_W(REQ_W), .IDX_W(IDX_W),
    .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES), .DEGREE(DEGREE)
  ) i_dp (
    .clk(clk), .rstN(rstN),
    .evPc(evPc), .evAddr(evAddr), .evReqId(evReqId),
    .cfgPerReq(cfgPerReq), .cfgPageStop(cfgPageStop), .cfgPcTag(cfgPcTag),
    .stb(stb), .trigHit(trigHit), .candDrop(candDrop), .lastStep(lastStep),
    .pfAddr(pfAddr), .pfPc(pfPc)
  );
endmodule

// File: rtl/stride_pf_chk.sv
module stride_pf_chk #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rstN,
  input logic              evValid,
  input logic [ADDR_W-1:0] evAddr,
  input logic              evMiss,
  input logic              evWrite,
  input logic              evInstr,
  input logic              evIsPf,
  input logic              cfgMissOnly,
  input logic              cfgReadOnly,
  input logic              cfgDataOnly,
  input logic              cfgPcTag,
  input logic              cfgPageStop,
  input logic              pfValid,
  input logic              pfReady,
  input logic [ADDR_W-1:0] pfAddr,
  input logic              loadStb
);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);

  logic [ADDR_W-PAGE_BITS-1:0] trigPage;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        trigPage <= '0;
    else if (loadStb) trigPage <= evAddr[ADDR_W-1:PAGE_BITS];
  end

  // R11
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && !pfReady && !loadStb |=> pfValid && $stable(pfAddr));

  // R4
  no_repeat_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    pfValid && pfReady && !loadStb |=> !pfValid || (pfAddr != $past(pfAddr)));

  // R5
  same_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgPageStop && pfValid |-> pfAddr[ADDR_W-1:PAGE_BITS] == trigPage);

  // R7
  miss_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid && cfgMissOnly && !evMiss |-> !loadStb);

  // R8
  read_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid && cfgReadOnly && evWrite |-> !loadStb);

  // R9
  data_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid && cfgDataOnly && evInstr |-> !loadStb);

  // R10
  pf_origin_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid && !cfgPcTag && evIsPf |-> !loadStb);
endmodule

bind stride_prefetch stride_pf_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) i_chk (
  .clk(clk), .rstN(rstN), .evValid(evValid), .evAddr(evAddr),
  .evMiss(evMiss), .evWrite(evWrite), .evInstr(evInstr), .evIsPf(evIsPf),
  .cfgMissOnly(cfgMissOnly), .cfgReadOnly(cfgReadOnly),
  .cfgDataOnly(cfgDataOnly), .cfgPcTag(cfgPcTag), .cfgPageStop(cfgPageStop),
  .pfValid(pfValid), .pfReady(pfReady), .pfAddr(pfAddr), .loadStb(stb.load)
);

// File: tb/test_stride_prefetch.sv
module test_stride_prefetch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evValid = 1'b0;
  logic [31:0] evPc = '0;
  logic [31:0] evAddr = '0;
  logic        evMiss = 1'b1;
  logic        evWrite = 1'b0;
  logic        evInstr = 1'b0;
  logic [1:0]  evReqId = '0;
  logic        evIsPf = 1'b0;
  logic        cfgMissOnly = 1'b0;
  logic        cfgReadOnly = 1'b0;
  logic        cfgDataOnly = 1'b0;
  logic        cfgPerReq = 1'b0;
  logic        cfgPageStop = 1'b0;
  logic        cfgPcTag = 1'b1;
  logic        pfReady = 1'b1;
  logic        pfValid;
  logic [31:0] pfAddr;
  logic [31:0] pfPc;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string curTag = "R1";

  typedef struct {
    logic [31:0] addr;
    logic [31:0] pc;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  stride_prefetch i_stride_prefetch (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evPc(evPc), .evAddr(evAddr),
    .evMiss(evMiss), .evWrite(evWrite), .evInstr(evInstr), .evReqId(evReqId),
    .evIsPf(evIsPf), .cfgMissOnly(cfgMissOnly), .cfgReadOnly(cfgReadOnly),
    .cfgDataOnly(cfgDataOnly), .cfgPerReq(cfgPerReq), .cfgPageStop(cfgPageStop),
    .cfgPcTag(cfgPcTag), .pfValid(pfValid), .pfReady(pfReady),
    .pfAddr(pfAddr), .pfPc(pfPc)
  );

  task automatic pushExp(input logic [31:0] addr, input logic [31:0] pc, input string tag);
    expItem_t e;
    e.addr = addr; e.pc = pc; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic sendEv(input logic [31:0] pc, input logic [31:0] addr,
                        input logic miss, input logic wr, input logic instr,
                        input logic [1:0] req, input logic isPf);
    @(posedge clk); #1;
    evValid = 1'b1; evPc = pc; evAddr = addr; evMiss = miss;
    evWrite = wr; evInstr = instr; evReqId = req; evIsPf = isPf;
    @(posedge clk); #1;
    evValid = 1'b0; evMiss = 1'b1; evWrite = 1'b0; evInstr = 1'b0; evIsPf = 1'b0;
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic ev(input logic [31:0] pc, input logic [31:0] addr);
    sendEv(pc, addr, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic checkEmpty(input string tag);
    @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL %s: missing prefetches actual=%0d outstanding expected=0 (next %h)",
               tag, expQ.size(), expQ[0].addr);
      expQ.delete();
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && pfValid && pfReady) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected prefetch actual=%h expected=none", curTag, pfAddr);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (pfAddr !== e.addr || pfPc !== e.pc) begin
          errors++;
          $display("FAIL %s: actual addr=%h pc=%h expected addr=%h pc=%h",
                   e.tag, pfAddr, pfPc, e.addr, e.pc);
        end
      end
    end
  end

  // Four ignored events, three qualifying, then the triggering one.
  // kind: 0 non-miss, 1 write, 2 instruction fetch, 3 prefetch-origin
  task automatic filterTest(input logic [31:0] pc, input logic [31:0] base,
                            input int kind, input string tag, input logic [31:0] expPc);
    curTag = tag;
    for (int i = 0; i < 4; i++)
      sendEv(pc, base + 32'(i * 64), kind != 0, kind == 1, kind == 2, 2'd0, kind == 3);
    for (int i = 4; i < 7; i++) ev(pc, base + 32'(i * 64));
    checkEmpty(tag);
    for (int k = 8; k <= 10; k++) pushExp(base + 32'(k * 64), expPc, tag);
    ev(pc, base + 32'(7 * 64));
    checkEmpty(tag);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: idle after reset
    @(negedge clk);
    checks++;
    if (pfValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual pfValid=%b expected=0", pfValid);
    end

    // R2 R3 R4: 48-byte stride, line dedupe
    curTag = "R2";
    ev(32'h100, 32'h1000); ev(32'h100, 32'h1030); ev(32'h100, 32'h1060);
    checkEmpty("R2");
    pushExp(32'h10C0, 32'h100, "R2"); pushExp(32'h1100, 32'h100, "R4");
    ev(32'h100, 32'h1090);
    checkEmpty("R4");
    pushExp(32'h1100, 32'h100, "R4"); pushExp(32'h1140, 32'h100, "R3");
    ev(32'h100, 32'h10C0);
    checkEmpty("R4");

    // R3 R10: negative stride trained by prefetch-origin events with tagging on
    curTag = "R10";
    for (int i = 0; i < 3; i++)
      sendEv(32'h104, 32'hE100 - 32'(i * 64), 1'b1, 1'b0, 1'b0, 2'd0, 1'b1);
    pushExp(32'hE000, 32'h104, "R3"); pushExp(32'hDFC0, 32'h104, "R3");
    pushExp(32'hDF80, 32'h104, "R10");
    sendEv(32'h104, 32'hE040, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1);
    checkEmpty("R10");

    // R5: page stop on, then off
    curTag = "R5";
    cfgPageStop = 1'b1;
    ev(32'h110, 32'h2000); ev(32'h110, 32'h2400);
    ev(32'h110, 32'h2800); ev(32'h110, 32'h2C00);
    checkEmpty("R5");
    cfgPageStop = 1'b0;
    pushExp(32'h3400, 32'h110, "R5"); pushExp(32'h3800, 32'h110, "R5");
    pushExp(32'h3C00, 32'h110, "R5");
    ev(32'h110, 32'h3000);
    checkEmpty("R5");

    // R7 R8 R9 R10: filters
    cfgMissOnly = 1'b1;
    filterTest(32'h108, 32'h5000, 0, "R7", 32'h108);
    cfgMissOnly = 1'b0;
    cfgReadOnly = 1'b1;
    filterTest(32'h10C, 32'h6000, 1, "R8", 32'h10C);
    cfgReadOnly = 1'b0;
    cfgDataOnly = 1'b1;
    filterTest(32'h114, 32'h7000, 2, "R9", 32'h114);
    cfgDataOnly = 1'b0;
    cfgPcTag = 1'b0;
    filterTest(32'h130, 32'h4000, 3, "R10", 32'h0);
    cfgPcTag = 1'b1;

    // R6: per-requester entries on
    curTag = "R6";
    cfgPerReq = 1'b1;
    sendEv(32'h128, 32'h8000, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
    sendEv(32'h128, 32'h9000, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
    sendEv(32'h128, 32'h8040, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
    sendEv(32'h128, 32'h9080, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
    sendEv(32'h128, 32'h8080, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
    sendEv(32'h128, 32'h9100, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
    checkEmpty("R6");
    pushExp(32'h8100, 32'h128, "R6"); pushExp(32'h8140, 32'h128, "R6");
    pushExp(32'h8180, 32'h128, "R6");
    sendEv(32'h128, 32'h80C0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
    pushExp(32'h9200, 32'h128, "R6"); pushExp(32'h9280, 32'h128, "R6");
    pushExp(32'h9300, 32'h128, "R6");
    sendEv(32'h128, 32'h9180, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
    checkEmpty("R6");
    // R6: requester ignored, shared entry thrashes
    cfgPerReq = 1'b0;
    for (int i = 0; i < 4; i++) begin
      sendEv(32'h134, 32'hA000 + 32'(i * 64), 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
      sendEv(32'h134, 32'hB000 + 32'(i * 64), 1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
    end
    checkEmpty("R6");

    // R11 R12: stall, then squash
    curTag = "R12";
    ev(32'h118, 32'hC000); ev(32'h118, 32'hC040); ev(32'h118, 32'hC080);
    pfReady = 1'b0;
    ev(32'h118, 32'hC0C0);
    @(negedge clk);
    checks++;
    if (pfValid !== 1'b1 || pfAddr !== 32'hC100) begin
      errors++;
      $display("FAIL R11: actual valid=%b addr=%h expected valid=1 addr=0000c100", pfValid, pfAddr);
    end
    pushExp(32'hC140, 32'h118, "R12"); pushExp(32'hC180, 32'h118, "R12");
    pushExp(32'hC1C0, 32'h118, "R12");
    ev(32'h118, 32'hC100);
    @(negedge clk);
    checks++;
    if (pfValid !== 1'b1 || pfAddr !== 32'hC140) begin
      errors++;
      $display("FAIL R12: actual valid=%b addr=%h expected valid=1 addr=0000c140", pfValid, pfAddr);
    end
    @(posedge clk); #1 pfReady = 1'b1;
    repeat (8) @(posedge clk);
    checkEmpty("R12");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule